// File: doc/BRIEF.md
# Packed-Lane Arithmetic Right Shifter

This block executes a signed shift-right-by-immediate on a packed vector of 64 or 128 bits. It takes one 32-bit instruction word together with the source vector and the previous destination vector. From the instruction's 7-bit immediate it decodes both the lane width and the shift count. It then shifts every lane arithmetically and registers the result one cycle later.

Two optional modes are selected by separate input pins. Rounding adds half of the shift weight to each lane before the shift. Accumulation adds each shifted lane into the matching lane of the old destination value. Carries never cross a lane boundary. An encoding that the block cannot execute raises an illegal flag and returns a zero result. The block neither reads nor writes condition flags.

Top module: `vec_sar_unit`

## Requirements
- R1: Each lane is shifted right arithmetically. Vacated high bits are filled with that lane's sign bit, and without rounding the shifted-out bits are simply dropped (truncation).
- R2: The immediate field `imm7 = insn[22:16]` is split into `hi4 = insn[22:19]` and `lo3 = insn[18:16]`. The lane width is 8, 16, 32 or 64 bits when the highest set bit of `hi4` is bit 0, 1, 2 or 3 respectively. The shift count is `2*width - imm7`, which ranges from 1 to width.
- R3: Vector form means `insn[31]=0`, `insn[29:23]=0011110` and `insn[15:10]=000001`. In this form, `insn[30]=1` processes all 128 bits. `insn[30]=0` processes only bits 63:0 and forces `result[127:64]` to zero.
- R4: Scalar form means `insn[31:23]=010111110` and `insn[15:10]=000001`. It processes one 64-bit lane in bits 63:0, and `result[127:64]` is zero.
- R5: When `rnd_en=1`, `2^(shift-1)` is added to the lane before shifting. The addition is carried out at one bit wider than the lane, so it cannot overflow.
- R6: When `acc_en=1`, each shifted lane is added to the same lane of `dst_old`, with the sum wrapping modulo 2^width. When `acc_en=0`, nothing is added.
- R7: A shift equal to the lane width gives 0 or all ones per lane, according to the lane's sign (truncating mode).
- R8: No carry from rounding or accumulation crosses into a neighbouring lane.
- R9: `illegal=1` and `result=0` in any of these cases:
  - `hi4=0000`;
  - vector form with `insn[30]=0` and 64-bit lanes;
  - scalar form with `insn[22]=0`;
  - the word matches neither form.

  Otherwise `illegal=0`.
- R10: `out_valid` equals `in_valid` delayed by one clock. `result` and `illegal` update only after a cycle with `in_valid=1`, and hold their values otherwise.
- R11: After reset, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| insn | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector |
| dst_old | input | 128 | Previous destination vector (accumulate addend) |
| rnd_en | input | 1 | Rounding mode enable |
| acc_en | input | 1 | Accumulate mode enable |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Shifted vector |
| illegal | output | 1 | Encoding could not be executed |

## Verification
The assertions assume that `in_valid` is held low while reset is active. They also assume that `insn`, the vectors and the mode pins are stable around each rising edge. The stimulus drives every input on the falling edge, keeps `in_valid` low throughout reset, and inserts idle cycles only after reset has been released. Illegal words are built deliberately from the legal layouts, by clearing `hi4`, by choosing a half-width 64-bit vector, or by corrupting fixed bits. This keeps every assertion antecedent within the defined encodings.

// File: rtl/vec_sar_unit.sv
module vec_sar_unit #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   insn,
  input  logic [VW-1:0] src_vec,
  input  logic [VW-1:0] dst_old,
  input  logic          rnd_en,
  input  logic          acc_en,
  output logic          out_valid,
  output logic [VW-1:0] result,
  output logic          illegal
);
  localparam int HW = VW / 2;

  wire [3:0] hi4    = insn[22:19];
  wire [6:0] imm7   = insn[22:16];
  wire       low_ok = insn[15:10] == 6'b000001;
  wire       vec_f  = !insn[31] && insn[29:23] == 7'b0011110 && low_ok;
  wire       scl_f  = insn[31:23] == 9'b010111110 && low_ok;

  logic [1:0] szc;
  always_comb begin
    if (hi4[3])      szc = 2'd3;
    else if (hi4[2]) szc = 2'd2;
    else if (hi4[1]) szc = 2'd1;
    else             szc = 2'd0;
  end

  wire [7:0] esz   = 8'd8 << szc;
  wire [7:0] shamt = {esz[6:0], 1'b0} - {1'b0, imm7};

  wire bad = !(vec_f || scl_f) || hi4 == 4'd0 ||
             (vec_f && !insn[30] && hi4[3]) || (scl_f && !hi4[3]);
  wire wide = vec_f && insn[30];

  logic [3:0][VW-1:0] cand;

  for (genvar gs = 0; gs < 4; gs++) begin : g_size
    localparam int E = 8 << gs;
    localparam int N = VW / E;
    for (genvar l = 0; l < N; l++) begin : g_lane
      wire [E-1:0]       a    = src_vec[l*E +: E];
      wire [E:0]         rinc = rnd_en ? ({{E{1'b0}}, 1'b1} << (shamt - 8'd1)) : '0;
      wire signed [E:0]  sum  = $signed({a[E-1], a}) + $signed(rinc);
      wire signed [E:0]  shd  = sum >>> shamt;
      wire [E-1:0]       add  = acc_en ? dst_old[l*E +: E] : '0;
      assign cand[gs][l*E +: E] = shd[E-1:0] + add;
    end
  end

  wire [VW-1:0] sel      = cand[szc];
  wire [VW-1:0] res_next = bad ? '0 : (wide ? sel : {{HW{1'b0}}, sel[HW-1:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_next;
        illegal <= bad;
      end
    end
  end
endmodule

module vec_sar_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [31:0]   insn,
  input logic          out_valid,
  input logic [VW-1:0] result,
  input logic          illegal
);
  localparam int HW = VW / 2;

  p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(illegal));
  p_zero_on_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> result == '0);
  p_no_hi4_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && insn[22:19] == 4'd0 |=> illegal);
  p_half_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !insn[30] |=> result[VW-1:HW] == '0);
endmodule

bind vec_sar_unit vec_sar_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
  .out_valid(out_valid), .result(result), .illegal(illegal)
);

// File: tb/vec_sar_unit_test.sv
`timescale 1ns/1ps
module vec_sar_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] src_vec = '0, dst_old = '0;
  logic         rnd_en = 1'b0, acc_en = 1'b0;
  logic         out_valid, illegal;
  logic [127:0] result;

  int total = 0, bad = 0;
  bit done = 0;

  logic         m_valid = 1'b0, m_ill = 1'b0;
  logic [127:0] m_res = '0;
  string        m_tag = "R11";

  always #2.5 clk = ~clk;

  vec_sar_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .src_vec(src_vec), .dst_old(dst_old), .rnd_en(rnd_en), .acc_en(acc_en),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic logic [31:0] mk_vec(bit q, logic [6:0] imm);
    return {1'b0, q, 1'b0, 6'b011110, imm, 6'b000001, 5'd3, 5'd7};
  endfunction

  function automatic logic [31:0] mk_scl(logic [6:0] imm);
    return {2'b01, 1'b0, 6'b111110, imm, 6'b000001, 5'd9, 5'd1};
  endfunction

  // behavioural reference: returns {illegal, result}
  function automatic logic [128:0] model(logic [31:0] w, logic [127:0] s,
                                         logic [127:0] d, bit rnd, bit acc);
    int h, e, sh, lanes;
    bit vec, scl, ill;
    logic [127:0] out;
    h   = int'(w[22:19]);
    vec = (w[31] == 0) && (w[29:23] == 7'b0011110) && (w[15:10] == 6'b000001);
    scl = (w[31:23] == 9'b010111110) && (w[15:10] == 6'b000001);
    if (h >= 8) e = 64; else if (h >= 4) e = 32; else if (h >= 2) e = 16; else e = 8;
    ill = !(vec || scl) || h == 0 || (vec && !w[30] && e == 64) || (scl && e != 64);
    if (ill) return {1'b1, 128'd0};
    sh    = 2 * e - int'(w[22:16]);
    lanes = (vec && w[30]) ? 128 / e : 64 / e;
    out   = '0;
    for (int i = 0; i < lanes; i++) begin
      logic signed [131:0] v;
      logic [131:0] mask, ln, dl, r;
      mask = ({132{1'b0}} | 132'd1) << e;
      mask = mask - 1;
      ln = ({4'd0, s} >> (i * e)) & mask;
      dl = ({4'd0, d} >> (i * e)) & mask;
      v = $signed(ln);
      if (ln[e-1]) v = v - $signed(mask) - 1;
      if (rnd) v = v + (132'sd1 <<< (sh - 1));
      v = v >>> sh;
      r = v & mask;
      if (acc) r = (r + dl) & mask;
      out = out | r[127:0] << (i * e);
    end
    return {1'b0, out};
  endfunction

  task automatic check_outs();
    total++;
    if (out_valid !== m_valid) begin
      bad++;
      $display("FAIL %s out_valid act=%b exp=%b", m_tag, out_valid, m_valid);
    end
    total++;
    if (result !== m_res || illegal !== m_ill) begin
      bad++;
      $display("FAIL %s result act=%h/%b exp=%h/%b", m_tag, result, illegal, m_res, m_ill);
    end
  endtask

  // each step: check the previous cycle's prediction, then apply new inputs
  task automatic step(bit v, logic [31:0] w, logic [127:0] s, logic [127:0] d,
                      bit rnd, bit acc, string tag);
    logic [128:0] p;
    @(negedge clk);
    check_outs();
    m_valid = v;
    if (v) begin
      p = model(w, s, d, rnd, acc);
      m_ill = p[128];
      m_res = p[127:0];
    end
    m_tag    = tag;
    in_valid = v; insn = w; src_vec = s; dst_old = d; rnd_en = rnd; acc_en = acc;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_outs();               // R11 reset state
    rst_n = 1'b1;

    // R1 R2 R3 R5 R6: sweep every size, shift, width and mode
    for (int ez = 0; ez < 4; ez++) begin
      for (int sh = 1; sh <= (8 << ez); sh++) begin
        for (int md = 0; md < 8; md++) begin
          logic [6:0] imm;
          imm = 7'(2 * (8 << ez) - sh);
          step(1, mk_vec(md[2] | (ez == 3), imm), rnd128(), rnd128(),
               md[0], md[1], "R2");
        end
      end
    end

    // R7 full-width shift, sign fill
    step(1, mk_vec(1, 7'd8),  {16{8'h80}}, '0, 0, 0, "R7");
    step(1, mk_vec(1, 7'd8),  {16{8'h7f}}, '0, 0, 0, "R7");
    step(1, mk_vec(1, 7'd64), {64'h8000_0000_0000_0001, 64'h7fff_ffff_ffff_ffff}, '0, 0, 0, "R7");
    step(1, mk_vec(1, 7'd64), {2{64'h8000_0000_0000_0000}}, '0, 1, 0, "R7");
    // R1 truncation of negatives
    step(1, mk_vec(0, 7'd15), {8{8'hff}}, '0, 0, 0, "R1");
    step(1, mk_vec(1, 7'd31), {8{16'h8001}}, '0, 0, 0, "R1");

    // R8 lane isolation: accumulate and round carries at lane edges
    step(1, mk_vec(1, 7'd15), {16{8'h7f}}, {16{8'hff}}, 1, 1, "R8");
    step(1, mk_vec(1, 7'd31), {8{16'hffff}}, {8{16'hffff}}, 1, 1, "R8");
    step(1, mk_vec(1, 7'd63), {4{32'h7fff_ffff}}, {4{32'hffff_ffff}}, 1, 1, "R8");

    // R4 scalar form
    step(1, mk_scl(7'd127), rnd128(), rnd128(), 0, 0, "R4");
    step(1, mk_scl(7'd64),  {64'h1, 64'h8000_0000_0000_0000}, '0, 0, 0, "R4");
    step(1, mk_scl(7'd100), rnd128(), rnd128(), 1, 1, "R4");

    // R9 illegal encodings
    step(1, mk_vec(1, 7'd5), rnd128(), rnd128(), 0, 0, "R9");
    step(1, mk_vec(0, 7'd70), rnd128(), rnd128(), 1, 1, "R9");
    step(1, mk_scl(7'd40), rnd128(), rnd128(), 0, 0, "R9");
    step(1, mk_vec(1, 7'd12) ^ 32'h0000_0400, rnd128(), rnd128(), 0, 0, "R9");
    step(1, mk_vec(1, 7'd12) | 32'h8000_0000, rnd128(), rnd128(), 0, 0, "R9");
    step(1, mk_vec(1, 7'd12), {16{8'h40}}, '0, 0, 0, "R9");

    // R10 gaps: result holds while idle
    step(1, mk_vec(1, 7'd20), rnd128(), rnd128(), 1, 0, "R10");
    step(0, mk_vec(1, 7'd9), rnd128(), rnd128(), 0, 1, "R10");
    step(0, mk_vec(0, 7'd3), rnd128(), rnd128(), 1, 1, "R10");
    step(1, mk_vec(0, 7'd40), rnd128(), rnd128(), 0, 1, "R10");
    step(0, '0, '0, '0, 0, 0, "R10");
    step(0, '0, '0, '0, 0, 0, "R10");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule